// File: doc/BRIEF.md
# Static memory bus width adapter

This block sits between a CPU-side request port and an external static memory bus for SRAM, ROM, flash and PC-card devices. The upper address bits pick one of eight chip-select segments. Each segment has a small configuration field that sets its data width and its wait states. The field can also put the segment into a PC-card mode, in which the access type comes from the address. A byte or word request becomes one or more external bus beats. A word to a narrow device is split into beats, lowest part first. Write data is replicated across the byte lanes. Read data is rotated and zero-filled, or assembled from several beats.

The width encoding depends on a boot-width pin that is captured while reset is asserted. This lets one boot image work from either a byte-wide or a word-wide device with all configuration fields still at zero. Every beat lasts one cycle plus its programmed wait states, and it is stretched further while the device holds the ready input low. A new request may follow the previous one with no idle cycle, but the bus is released for one idle cycle after every four back-to-back beats.

Top module: `stmem_width_adapter`

## Requirements
- R1: The segment index is request address bits 30:28, and only that segment's bit of `bus_cs_n` is driven low during each of its beats. `bus_addr` carries request address bits 27:0. All eight configuration fields reset to zero.
- R2: The configuration field holds three parts. Bits 1:0 are the width code. Bits 4:2 are the wait-state count, and the values 5, 6 and 7 act as 4. Bit 5 enables PC-card mode.
- R3: `boot_pin` is captured on every clock while `rst_n` is low. With a captured 0, width code 00 means 32 bits, 11 means 8 bits, and 01 or 10 mean 16 bits. With a captured 1, the code is bitwise inverted before decoding, for every segment. Changes of `boot_pin` after reset have no effect.
- R4: A word write to a 16-bit segment takes two beats. The low half goes first, at the aligned address, then the high half at address +2, and each half appears on both halves of `bus_dout`. A word write to an 8-bit segment takes four beats from the least significant byte up, with the address rising by one each beat and the byte on all four lanes.
- R5: A byte write takes one beat at the unmodified address, with the byte replicated on all four lanes of `bus_dout`, whatever the segment width.
- R6: A word access to an address that is not word aligned behaves as if address bits 1:0 were zero.
- R7: On a byte read, the addressed byte is returned in `rsp_rdata[7:0]` with bits 31:8 zero. The byte is taken from lane address[1:0] on a 32-bit segment, from D15:8 or D7:0 by address bit 0 on a 16-bit segment, and from D7:0 on an 8-bit segment. A word read from a narrow segment is assembled low part first from D15:0 or D7:0. A write response returns zero.
- R8: In PC-card mode, address bits 27:26 select the access type: 00 is 8-bit attribute memory, 01 is 16-bit common memory, 10 is 8-bit I/O, and 11 is 16-bit I/O.
- R9: A word access to 16-bit PC-card I/O takes a single beat. On a read only D15:0 is returned, with the upper half zero. When address bits 27:25 of a PC-card access are all ones, `bus_addr[25]` is driven 0 and `bus_addr[1]` is driven 1.
- R10: Each beat keeps its chip select and strobe active for 1 + wait-state cycles. `rsp_valid` is high for exactly one cycle, the cycle after the last beat ends.
- R11: While `bus_ready` is low once the wait states of a beat have run out, that beat holds its outputs unchanged and does not end.
- R12: `req_ready` is high when the block is idle. It is also high in the final cycle of a request's last beat, provided fewer than four beats have run back to back. After four consecutive beats, all chip selects go high for exactly one cycle, including between the beats of a single request.
- R13: `bus_oe_n` is low only during read beats and `bus_we_n` only during write beats, never both at once. `bus_dout` is zero during reads. After reset, all selects and strobes are high, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin | input | 1 | Boot-width strap, captured during reset |
| cfg_we | input | 1 | Configuration field write strobe |
| cfg_sel | input | 3 | Segment whose field is written |
| cfg_data | input | 6 | New configuration field value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at the clock edge when also valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 31 | Request byte address |
| req_wdata | input | 32 | Write data (byte in bits 7:0) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, zero for writes |
| bus_cs_n | output | 8 | Active-low segment selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_addr | output | 28 | External byte address |
| bus_dout | output | 32 | External write data |
| bus_din | input | 32 | External read data |
| bus_ready | input | 1 | Device ready; low stretches a beat |

## Verification
A request presented before a clock edge is accepted at that edge, and its first beat is visible right after that edge. Every beat then lasts exactly 1 + wait-state cycles, plus the cycles the bench holds `bus_ready` low, and the completion pulse falls in the cycle after the last beat. The bench derives the beat count, beat length, address, lane data and response value from its own model of the configuration. It compares the bus at the falling edge of every cycle of every beat, so a beat that is too early, too late, too long or missing shows up as a mismatch in a named cycle. The back-to-back case is stepped cycle by cycle against a fixed expected trace that contains the idle cycle forced after four beats.

// File: rtl/stmem_width_adapter.sv
module stmem_width_adapter #(
  parameter int SEG_COUNT = 8,
  parameter int MAX_WAIT  = 4,
  parameter int BURST_MAX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_pin,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [5:0]           cfg_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_byte,
  input  logic [30:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [SEG_COUNT-1:0] bus_cs_n,
  output logic                 bus_oe_n,
  output logic                 bus_we_n,
  output logic [27:0]          bus_addr,
  output logic [31:0]          bus_dout,
  input  logic [31:0]          bus_din,
  input  logic                 bus_ready
);
  localparam int SEGW = $clog2(SEG_COUNT);
  localparam int BCW  = $clog2(BURST_MAX + 1);
  localparam logic [2:0]     WS_CAP    = 3'(MAX_WAIT);
  localparam logic [BCW-1:0] BURST_CAP = BCW'(BURST_MAX);
  localparam logic [1:0] W8 = 2'd0, W16 = 2'd1, W32 = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP} state_t;

  state_t          st;
  logic            boot_q;
  logic [5:0]      cfg_q [SEG_COUNT];
  logic            t_write, t_byte, t_pcm, t_io16;
  logic [1:0]      t_w, t_last, beat;
  logic [27:0]     t_base;
  logic [31:0]     t_wdata, rd_acc, rd_merge, lanes;
  logic [SEGW-1:0] t_seg;
  logic [2:0]      t_ws, wcnt;
  logic [BCW-1:0]  bcnt;

  // decode of the incoming request
  wire [SEGW-1:0] n_seg  = req_addr[28 +: SEGW];
  wire [5:0]      n_cfg  = cfg_q[n_seg];
  wire [1:0]      n_code = n_cfg[1:0] ^ {2{boot_q}};
  wire            n_io16 = n_cfg[5] && (req_addr[27:26] == 2'b11);
  wire [2:0]      n_ws   = (n_cfg[4:2] > WS_CAP) ? WS_CAP : n_cfg[4:2];
  logic [1:0]     n_w, n_last;

  always_comb begin
    if (n_cfg[5])           n_w = req_addr[26] ? W16 : W8;
    else if (n_code == 2'b00) n_w = W32;
    else if (n_code == 2'b11) n_w = W8;
    else                    n_w = W16;
    if (req_byte || n_w == W32 || n_io16) n_last = 2'd0;
    else if (n_w == W16)                  n_last = 2'd1;
    else                                  n_last = 2'd3;
  end

  // beat address and lanes
  wire [27:0] off   = (t_w == W8)  ? {26'b0, beat} :
                      (t_w == W16) ? {26'b0, beat[0], 1'b0} : 28'b0;
  wire [27:0] raw   = t_base + off;
  wire        remap = t_pcm && (t_base[27:25] == 3'b111);
  assign bus_addr = remap ? {raw[27:26], 1'b0, raw[24:2], 1'b1, raw[0]} : raw;

  always_comb begin
    if (!t_write)        lanes = 32'b0;
    else if (t_byte)     lanes = {4{t_wdata[7:0]}};
    else if (t_w == W32) lanes = t_wdata;
    else if (t_w == W16) lanes = {2{t_wdata[{beat[0], 4'b0} +: 16]}};
    else                 lanes = {4{t_wdata[{beat, 3'b0} +: 8]}};
  end
  assign bus_dout = lanes;

  wire [1:0] lane = (t_w == W32) ? t_base[1:0] :
                    (t_w == W16) ? {1'b0, t_base[0]} : 2'b00;

  always_comb begin
    rd_merge = rd_acc;
    if (t_byte)          rd_merge = {24'b0, bus_din[{lane, 3'b0} +: 8]};
    else if (t_w == W32) rd_merge = bus_din;
    else if (t_io16)     rd_merge = {16'b0, bus_din[15:0]};
    else if (t_w == W16) rd_merge[{beat[0], 4'b0} +: 16] = bus_din[15:0];
    else                 rd_merge[{beat, 3'b0} +: 8] = bus_din[7:0];
  end

  // sequencing
  wire           in_bus   = (st == S_BUS);
  wire           beat_end = in_bus && (wcnt == 3'd0) && bus_ready;
  wire           last     = (beat == t_last);
  wire [BCW-1:0] bcnt_inc = bcnt + 1'b1;

  assign req_ready = (st == S_IDLE) || (beat_end && last && (bcnt_inc < BURST_CAP));
  wire accept = req_valid && req_ready;

  assign bus_cs_n = in_bus ? ~(SEG_COUNT'(1) << t_seg) : '1;
  assign bus_oe_n = !(in_bus && !t_write);
  assign bus_we_n = !(in_bus && t_write);

  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= boot_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_COUNT; i++) cfg_q[i] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_sel[SEGW-1:0]] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {t_write, t_byte, t_pcm, t_io16} <= '0;
      t_w <= W32; t_last <= '0; beat <= '0;
      t_base <= '0; t_wdata <= '0; rd_acc <= '0;
      t_seg <= '0; t_ws <= '0; wcnt <= '0; bcnt <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= beat_end && last;
      if (beat_end && last) rsp_rdata <= t_write ? 32'b0 : rd_merge;

      if (accept) begin
        t_write <= req_write; t_byte <= req_byte;
        t_pcm   <= n_cfg[5];  t_io16 <= n_io16 && !req_byte;
        t_w     <= n_w;       t_last <= n_last;
        t_base  <= req_byte ? req_addr[27:0] : {req_addr[27:2], 2'b00};
        t_wdata <= req_wdata; t_seg <= n_seg; t_ws <= n_ws;
        beat <= '0; wcnt <= n_ws; rd_acc <= '0;
      end else if (beat_end && !last) begin
        beat <= beat + 1'b1; rd_acc <= rd_merge; wcnt <= t_ws;
      end else if (in_bus && wcnt != 3'd0) begin
        wcnt <= wcnt - 1'b1;
      end

      if (beat_end)           bcnt <= (bcnt_inc == BURST_CAP) ? '0 : bcnt_inc;
      else if (st == S_IDLE)  bcnt <= '0;

      case (st)
        S_IDLE: if (accept) st <= S_BUS;
        S_BUS:  if (beat_end) begin
                  if (last)                         st <= accept ? S_BUS : S_IDLE;
                  else if (bcnt_inc == BURST_CAP)   st <= S_GAP;
                end
        S_GAP:  st <= S_BUS;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n)); // R13
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus && wcnt != 3'd0) |=> (!rsp_valid && $stable(bus_cs_n) && $stable(bus_addr))); // R10
  AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus && wcnt == 3'd0 && !bus_ready) |=> ($stable(bus_cs_n) && $stable(bus_addr) && !rsp_valid)); // R11
  AST_BURST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end && bcnt == BURST_CAP - 1'b1) |=> (bus_cs_n == '1)); // R12
  AST_IO16_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus && t_io16) |-> (beat == 2'd0)); // R9
endmodule

// File: tb/stmem_width_adapter_tb.sv
module stmem_width_adapter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, boot_pin = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_sel = '0; logic [5:0] cfg_data = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, bus_ready = 1'b1;
  logic [30:0] req_addr = '0; logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, bus_oe_n, bus_we_n;
  logic [31:0] rsp_rdata, bus_dout, bus_din;
  logic [7:0] bus_cs_n; logic [27:0] bus_addr;

  int checks = 0, fails = 0;
  logic [5:0] cfg_m [8];
  bit boot_m = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] din_of(input logic [27:0] x);
    return {x[7:0] ^ 8'hC3, x[7:0] + 8'd7, ~x[7:0], x[7:0] ^ x[15:8]};
  endfunction
  assign bus_din = din_of(bus_addr);

  stmem_width_adapter dut_i (.clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ready(bus_ready));

  task automatic chk(input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic do_reset(input bit bp);
    @(negedge clk); rst_n = 1'b0; boot_pin = bp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; boot_m = bp;
    for (int i = 0; i < 8; i++) cfg_m[i] = '0;
  endtask

  task automatic set_cfg(input int s, input logic [5:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 3'(s); cfg_data = v; cfg_m[s] = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic access(input bit wr, input bit by, input logic [30:0] a,
                        input logic [31:0] d, input int stall, input string tag);
    logic [5:0] cb; logic [1:0] code, ln; bit pcm, io16; int w, ws, nb;
    logic [27:0] base, ea; logic [31:0] dv, ed, er; logic [7:0] csx;
    cb = cfg_m[a[30:28]]; pcm = cb[5]; code = cb[1:0] ^ {2{boot_m}};
    if (pcm) w = a[26] ? 16 : 8;
    else w = (code == 2'b00) ? 32 : (code == 2'b11) ? 8 : 16;
    io16 = pcm && (a[27:26] == 2'b11) && !by;
    ws = (cb[4:2] > 3'd4) ? 4 : int'(cb[4:2]);
    nb = (by || w == 32 || io16) ? 1 : (w == 16) ? 2 : 4;
    base = by ? a[27:0] : {a[27:2], 2'b00};
    csx = ~(8'h01 << a[30:28]); er = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int b = 0; b < nb; b++) begin
      ea = base + ((w == 8) ? 28'(b) : (w == 16) ? 28'(2 * b) : 28'd0);
      if (pcm && base[27:25] == 3'b111) begin ea[25] = 1'b0; ea[1] = 1'b1; end
      dv = din_of(ea);
      if (!wr) ed = '0;
      else if (by) ed = {4{d[7:0]}};
      else if (w == 32) ed = d;
      else if (w == 16) ed = {2{d[b*16 +: 16]}};
      else ed = {4{d[b*8 +: 8]}};
      if (!wr) begin
        if (by) begin
          ln = (w == 32) ? base[1:0] : (w == 16) ? {1'b0, base[0]} : 2'b00;
          er = {24'h0, dv[ln*8 +: 8]};
        end else if (w == 32) er = dv;
        else if (io16) er = {16'h0, dv[15:0]};
        else if (w == 16) er[b*16 +: 16] = dv[15:0];
        else er[b*8 +: 8] = dv[7:0];
      end
      for (int c = 0; c < ws + 1 + ((b == 0) ? stall : 0); c++) begin
        @(negedge clk);
        req_valid = 1'b0;
        bus_ready = !(b == 0 && c >= ws && c < ws + stall);
        chk($sformatf("%s beat%0d cycle%0d", tag, b, c),
            {9'h0, bus_cs_n, bus_oe_n, bus_we_n, bus_addr, bus_dout, rsp_valid},
            {9'h0, csx, wr, !wr, ea, ed, 1'b0});
      end
    end
    @(negedge clk); bus_ready = 1'b1;
    chk({tag, " response"}, {39'h0, rsp_valid, rsp_rdata, bus_cs_n}, {39'h0, 1'b1, er, 8'hFF});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_0042);
    do_reset(1'b0);
    @(negedge clk);
    chk("R13 reset idle outputs", {68'h0, bus_cs_n, bus_oe_n, bus_we_n, rsp_valid, req_ready},
        {68'h0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1});

    // R1 R3: zeroed field with boot low is 32-bit, no waits
    access(1, 0, 31'h3000_0104, 32'hCAFE_F00D, 0, "R1 R3 reset field 32-bit write");
    access(0, 0, 31'h3000_0208, 32'h0, 0, "R1 word read 32-bit");

    set_cfg(1, 6'h09);  // 16-bit, 2 waits
    set_cfg(2, 6'h07);  // 8-bit, 1 wait
    access(1, 0, 31'h1000_0012, 32'h0123_4567, 0, "R4 R6 R10 unaligned word 16-bit");
    access(1, 0, 31'h2000_0040, 32'h89AB_CDEF, 0, "R4 word write 8-bit");
    access(0, 0, 31'h2000_0083, 32'h0, 0, "R7 R6 word read 8-bit");
    access(0, 0, 31'h1000_0020, 32'h0, 0, "R7 word read 16-bit");
    access(1, 1, 31'h2000_0003, 32'h0000_00A5, 0, "R5 byte write 8-bit");
    access(1, 1, 31'h3000_0006, 32'h1234_565A, 0, "R5 byte write 32-bit");
    access(0, 1, 31'h3000_0016, 32'h0, 0, "R7 byte read lane2 32-bit");
    access(0, 1, 31'h1000_0031, 32'h0, 0, "R7 byte read odd 16-bit");
    access(0, 1, 31'h2000_0033, 32'h0, 0, "R7 byte read 8-bit");

    set_cfg(4, 6'h1C);  // 32-bit, wait code 7 -> 4
    access(0, 0, 31'h4000_0100, 32'h0, 0, "R2 wait clamp");
    set_cfg(3, 6'h14);  // 32-bit, 5 -> 4 waits
    access(1, 0, 31'h3000_0200, 32'h5555_AAAA, 0, "R2 R10 wait five clamps");

    set_cfg(5, 6'h20);  // PC-card mode, no waits
    access(0, 0, 31'h5000_0010, 32'h0, 0, "R8 attribute 8-bit");
    access(1, 0, 31'h5400_0010, 32'h1357_9BDF, 0, "R8 common 16-bit");
    access(0, 0, 31'h5800_0020, 32'h0, 0, "R8 io 8-bit");
    access(0, 0, 31'h5C00_0004, 32'h0, 0, "R9 io16 word read single");
    access(1, 0, 31'h5E00_0000, 32'hDEAD_BEEF, 0, "R9 io16 remap write");
    access(0, 0, 31'h5E00_0100, 32'h0, 0, "R9 io16 remap read");

    access(1, 0, 31'h1000_0200, 32'hFEDC_BA98, 3, "R11 ready stretch 16-bit");
    access(0, 1, 31'h3000_0001, 32'h0, 2, "R11 ready stretch byte read");

    // R12: byte write chained into a word to an 8-bit segment
    set_cfg(6, 6'h00);
    set_cfg(7, 6'h03);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_byte = 1; req_addr = 31'h6000_0001; req_wdata = 32'h0000_00AB;
    @(posedge clk);
    @(negedge clk);
    chk("R12 chain c0 byte beat", {req_ready, bus_cs_n, bus_we_n, bus_addr, bus_dout},
        {1'b1, 8'hBF, 1'b0, 28'h000_0001, 32'hABAB_ABAB});
    req_byte = 0; req_addr = 31'h7000_0010; req_wdata = 32'h1122_3344;
    @(negedge clk); req_valid = 0;
    chk("R12 chain c1", {rsp_valid, bus_cs_n, bus_addr, bus_dout}, {1'b1, 8'h7F, 28'h10, 32'h4444_4444});
    @(negedge clk);
    chk("R12 chain c2", {rsp_valid, bus_cs_n, bus_addr, bus_dout}, {1'b0, 8'h7F, 28'h11, 32'h3333_3333});
    @(negedge clk);
    chk("R12 chain c3", {req_ready, bus_cs_n, bus_addr, bus_dout}, {1'b0, 8'h7F, 28'h12, 32'h2222_2222});
    @(negedge clk);
    chk("R12 chain c4 idle gap", {bus_cs_n, bus_we_n}, {8'hFF, 1'b1});
    @(negedge clk);
    chk("R12 chain c5", {req_ready, bus_cs_n, bus_addr, bus_dout}, {1'b1, 8'h7F, 28'h13, 32'h1111_1111});
    @(negedge clk);
    chk("R12 chain c6 response", {rsp_valid, rsp_rdata, bus_cs_n}, {1'b1, 32'h0, 8'hFF});

    for (int s = 0; s < 8; s++) set_cfg(s, 6'($urandom()));
    for (int i = 0; i < 150; i++) begin
      r = $urandom();
      access(r[0], r[1], {r[4:2], 28'($urandom())}, $urandom(), int'(r[6:5]) % 3, "R4 R7 R8 random");
    end

    // R3: boot pin high inverts decoding
    do_reset(1'b1);
    @(negedge clk); boot_pin = 1'b0;
    access(1, 0, 31'h0000_0100, 32'hA1B2_C3D4, 0, "R3 boot high zero field is 8-bit");
    set_cfg(1, 6'h03);
    access(0, 0, 31'h1000_0040, 32'h0, 0, "R3 boot high code 11 is 32-bit");
    set_cfg(2, 6'h01);
    access(1, 0, 31'h2000_0080, 32'h7654_3210, 0, "R3 boot high code 01 is 16-bit");
    for (int i = 0; i < 40; i++) begin
      r = $urandom();
      if (i % 8 == 0) set_cfg(int'(r[9:7]), 6'($urandom()));
      access(r[0], r[1], {r[4:2], 28'($urandom())}, $urandom(), 0, "R3 R9 random boot high");
    end
    summary();
  end
endmodule